// File: doc/BRIEF.md
# Interrupt Status and Enable Register Block

This block keeps the event status flags of a serial bus controller and the mask that decides which of those flags reach the single level-sensitive interrupt line. The transfer engine next to it sends one-cycle event pulses (eight sources: missing acknowledge, lost arbitration, transfer done, receive ready, transmit ready, receive drain, transmit drain and bus idle). Each pulse latches a sticky status flag. A live bus-activity input is shown as a read-only flag beside them.

Software reaches the block through a 16-bit register port that accepts only byte and aligned halfword accesses. Status flags are cleared by writing ones back to them. The mask is never written directly: one write-only port sets mask bits and another clears them, so concurrent agents never need a read-modify-write. A second, read-only view gives the status already ANDed with the mask. A 32-bit or misaligned halfword access changes nothing, reads as zero and raises a flag for that cycle.

Top module: `intr_stat_en`

## Requirements
- R1: After reset, every status flag and every mask bit is 0 and `irq` is low.
- R2: A 1 on `evt_pulse[i]` sets status flag i at the next clock edge. The flag stays set until software clears it. Flag positions: bit 0 missing acknowledge, 1 lost arbitration, 2 transfer done, 3 receive ready, 4 transmit ready, 5 receive drain, 6 transmit drain, 7 bus idle.
- R3: A write to the raw status register (byte offset 0x0) clears exactly the flags written as 1. Flags written as 0 keep their value.
- R4: A write to the mask-set port (offset 0x6) sets the mask bits written as 1 and leaves the others alone. This port reads as 0.
- R5: A write to the mask-clear port (offset 0x8) clears the mask bits written as 1 and leaves the others alone. This port reads as 0.
- R6: `irq` is high exactly when some status flag and its mask bit are both 1. The bus-activity flag never drives `irq`.
- R7: If an event pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R8: Bit 12 of the raw status register always shows `bus_busy`. Writes do not change it.
- R9: The masked view (offset 0x2) reads the status flags ANDed with the mask in bits 7:0. The mask itself reads at offset 0x4. Unused bits and unmapped offsets read 0.
- R10: For a byte access (`acc_size` = 0), `acc_addr[0]` picks the lane: 0 selects bits 7:0 and 1 selects bits 15:8. A write uses only `acc_wdata[7:0]` and touches only that lane. A read returns the lane in `acc_rdata[7:0]` with zero above.
- R11: An access with `acc_size` = 2 (32-bit) or 3, or a halfword (`acc_size` = 1) with `acc_addr[0]` = 1, raises `bad_access` in that cycle, changes no register and reads 0.
- R12: Writes to the masked view or the mask view have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | Register access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W (4) | Byte address of the access |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data, valid in the access cycle |
| bad_access | output | 1 | Unsupported access width or alignment this cycle |
| evt_pulse | input | NUM_EVT (8) | One-cycle event pulses from the transfer engine |
| bus_busy | input | 1 | Live bus-activity level |
| irq | output | 1 | Level interrupt |

## Verification
Read data and `bad_access` are combinational, so they are due in the access cycle itself. The bench samples them 2 ns after the falling edge on which it drove the access. A write or an event pulse updates the state at the next rising edge, and `irq` follows from the registered state, so their effect is due one edge later. The bench's behavioural model takes the same inputs at each rising edge and compares `irq` on every falling edge. Every later readback uses the model state from the last rising edge.

// File: rtl/isr_pkg.sv
`timescale 1ns/1ps
package isr_pkg;
  localparam int REG_W = 16;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    RG_RAW    = 3'd0,
    RG_MASKED = 3'd1,
    RG_ENVIEW = 3'd2,
    RG_ENSET  = 3'd3,
    RG_ENCLR  = 3'd4
  } reg_idx_e;

  // legal widths: byte anywhere, halfword on even address only
  function automatic logic size_ok(input logic [1:0] sz, input logic lane);
    return (sz == SZ_BYTE) || ((sz == SZ_HALF) && !lane);
  endfunction

  // bits of the 16-bit register that an access touches
  function automatic logic [REG_W-1:0] lane_mask(input logic [1:0] sz, input logic lane);
    logic [REG_W-1:0] m;
    if (sz == SZ_BYTE) m = lane ? 16'hFF00 : 16'h00FF;
    else if (sz == SZ_HALF) m = 16'hFFFF;
    else m = '0;
    return m;
  endfunction

  // byte writes carry their data in the low byte
  function automatic logic [REG_W-1:0] align_wdata(input logic [1:0] sz, input logic lane,
                                                   input logic [REG_W-1:0] d);
    logic [REG_W-1:0] r;
    if (sz == SZ_BYTE) r = lane ? {d[7:0], 8'h00} : {8'h00, d[7:0]};
    else r = d;
    return r;
  endfunction

  // byte reads return their lane in the low byte
  function automatic logic [REG_W-1:0] pick_rdata(input logic [1:0] sz, input logic lane,
                                                  input logic [REG_W-1:0] w);
    logic [REG_W-1:0] r;
    if (sz == SZ_BYTE) r = lane ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
    else if (sz == SZ_HALF) r = w;
    else r = '0;
    return r;
  endfunction
endpackage

// File: rtl/isr_access_decode.sv
`timescale 1ns/1ps
module isr_access_decode
  import isr_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int NUM_EVT = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_en,
  input  logic                acc_wr,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic [1:0]          acc_size,
  input  logic [REG_W-1:0]    acc_wdata,
  output logic                bad_access,
  output logic                rd_ok,
  output logic                rd_lane,
  output logic [ADDR_W-2:0]   rd_idx,
  output logic [NUM_EVT-1:0]  raw_clr_ones,
  output logic [NUM_EVT-1:0]  en_set_ones,
  output logic [NUM_EVT-1:0]  en_clr_ones
);
  localparam int IDX_W = ADDR_W - 1;

  logic               lane;
  logic               legal;
  logic               wr_go;
  logic [IDX_W-1:0]   idx;
  logic [REG_W-1:0]   ones;

  assign lane  = acc_addr[0];
  assign idx   = acc_addr[ADDR_W-1:1];
  assign legal = size_ok(acc_size, lane);
  assign wr_go = acc_en && acc_wr && legal;
  assign ones  = lane_mask(acc_size, lane) & align_wdata(acc_size, lane, acc_wdata);

  assign bad_access   = acc_en && !legal;
  assign rd_ok        = acc_en && !acc_wr && legal;
  assign rd_lane      = lane;
  assign rd_idx       = idx;
  assign raw_clr_ones = (wr_go && idx == IDX_W'(RG_RAW))   ? ones[NUM_EVT-1:0] : '0;
  assign en_set_ones  = (wr_go && idx == IDX_W'(RG_ENSET)) ? ones[NUM_EVT-1:0] : '0;
  assign en_clr_ones  = (wr_go && idx == IDX_W'(RG_ENCLR)) ? ones[NUM_EVT-1:0] : '0;

  // R10
  lane_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_size == SZ_BYTE && !acc_addr[0]) |-> (ones[15:8] == 8'h00));
  // R10
  lane_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_size == SZ_BYTE && acc_addr[0]) |-> (ones[7:0] == 8'h00));
  // R11
  bad_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> (raw_clr_ones == '0 && en_set_ones == '0 && en_clr_ones == '0 && !rd_ok));
endmodule

// File: rtl/isr_status_bank.sv
`timescale 1ns/1ps
module isr_status_bank #(
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt,
  input  logic [NUM_EVT-1:0] clr_ones,
  output logic [NUM_EVT-1:0] stat_q
);
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flag_q <= 1'b0;
      else if (evt[i])      flag_q <= 1'b1;   // event beats a same-cycle clear
      else if (clr_ones[i]) flag_q <= 1'b0;
    end
    assign stat_q[i] = flag_q;
  end

  // R2, R7
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((stat_q & $past(evt)) == $past(evt)));
  // R3
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_ones & ~evt)) |=> ((stat_q & $past(clr_ones & ~evt)) == '0));
  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|stat_q) |=> (((stat_q | $past(clr_ones)) & $past(stat_q)) == $past(stat_q)));
endmodule

// File: rtl/isr_enable_bank.sv
`timescale 1ns/1ps
module isr_enable_bank #(
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] set_ones,
  input  logic [NUM_EVT-1:0] clr_ones,
  output logic [NUM_EVT-1:0] en_q
);
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_en
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           bit_q <= 1'b0;
      else if (set_ones[i]) bit_q <= 1'b1;
      else if (clr_ones[i]) bit_q <= 1'b0;
    end
    assign en_q[i] = bit_q;
  end

  // R4
  set_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_ones) |=> ((en_q & $past(set_ones)) == $past(set_ones)));
  // R5
  clr_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_ones & ~set_ones)) |=> ((en_q & $past(clr_ones & ~set_ones)) == '0));
  // R4, R5
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ones == '0 && clr_ones == '0) |=> (en_q == $past(en_q)));
endmodule

// File: rtl/intr_stat_en.sv
`timescale 1ns/1ps
module intr_stat_en
  import isr_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int NUM_EVT  = 8,
  parameter int BUSY_POS = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_en,
  input  logic               acc_wr,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [1:0]         acc_size,
  input  logic [15:0]        acc_wdata,
  output logic [15:0]        acc_rdata,
  output logic               bad_access,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic               bus_busy,
  output logic               irq
);
  localparam int IDX_W = ADDR_W - 1;

  logic               rd_ok;
  logic               rd_lane;
  logic [IDX_W-1:0]   rd_idx;
  logic [NUM_EVT-1:0] raw_clr_ones;
  logic [NUM_EVT-1:0] en_set_ones;
  logic [NUM_EVT-1:0] en_clr_ones;
  logic [NUM_EVT-1:0] stat_q;
  logic [NUM_EVT-1:0] en_q;
  logic [REG_W-1:0]   raw_word;
  logic [REG_W-1:0]   sel_word;

  isr_access_decode #(.ADDR_W(ADDR_W), .NUM_EVT(NUM_EVT)) u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_en       (acc_en),
    .acc_wr       (acc_wr),
    .acc_addr     (acc_addr),
    .acc_size     (acc_size),
    .acc_wdata    (acc_wdata),
    .bad_access   (bad_access),
    .rd_ok        (rd_ok),
    .rd_lane      (rd_lane),
    .rd_idx       (rd_idx),
    .raw_clr_ones (raw_clr_ones),
    .en_set_ones  (en_set_ones),
    .en_clr_ones  (en_clr_ones)
  );

  isr_status_bank #(.NUM_EVT(NUM_EVT)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_pulse),
    .clr_ones (raw_clr_ones),
    .stat_q   (stat_q)
  );

  isr_enable_bank #(.NUM_EVT(NUM_EVT)) u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_ones (en_set_ones),
    .clr_ones (en_clr_ones),
    .en_q     (en_q)
  );

  always_comb begin
    raw_word = '0;
    raw_word[NUM_EVT-1:0] = stat_q;
    raw_word[BUSY_POS]    = bus_busy;
  end

  always_comb begin
    sel_word = '0;
    case (rd_idx)
      IDX_W'(RG_RAW):    sel_word = raw_word;
      IDX_W'(RG_MASKED): sel_word[NUM_EVT-1:0] = stat_q & en_q;
      IDX_W'(RG_ENVIEW): sel_word[NUM_EVT-1:0] = en_q;
      default:           sel_word = '0;
    endcase
  end

  assign acc_rdata = rd_ok ? pick_rdata(acc_size, rd_lane, sel_word) : '0;
  assign irq       = |(stat_q & en_q);

  // R6
  irq_follows_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(evt_pulse) & en_q)) |-> irq);
  // R11
  bad_keeps_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |=> $stable(en_q));
  // R11
  bad_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> (acc_rdata == '0));
  // R12
  view_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && (acc_addr[ADDR_W-1:1] == IDX_W'(RG_MASKED) ||
                          acc_addr[ADDR_W-1:1] == IDX_W'(RG_ENVIEW)))
    |=> $stable(en_q));
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (!irq && stat_q == '0 && en_q == '0));
endmodule

// File: tb/intr_stat_en_bench.sv
`timescale 1ns/1ps
module intr_stat_en_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0;
  logic        acc_wr = 1'b0;
  logic [3:0]  acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [15:0] acc_wdata = '0;
  logic [15:0] acc_rdata;
  logic        bad_access;
  logic [7:0]  evt = '0;
  logic        bus_busy = 1'b0;
  logic        irq;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;

  // behavioural model state
  logic [7:0] m_stat = '0;
  logic [7:0] m_en = '0;

  always #10 clk = ~clk;

  intr_stat_en u_intr_stat_en (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .bad_access(bad_access), .evt_pulse(evt),
    .bus_busy(bus_busy), .irq(irq)
  );

  function automatic bit want_bad(input logic [3:0] a, input logic [1:0] sz);
    if (sz == 2'd0) return 1'b0;
    if (sz == 2'd1 && a[0] == 1'b0) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [15:0] want_read(input logic [3:0] a, input logic [1:0] sz);
    logic [15:0] w;
    if (want_bad(a, sz)) return 16'h0000;
    case (a[3:1])
      3'd0: w = {3'b000, bus_busy, 4'h0, m_stat};
      3'd1: w = {8'h00, m_stat & m_en};
      3'd2: w = {8'h00, m_en};
      default: w = 16'h0000;
    endcase
    if (sz == 2'd0) return a[0] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
    return w;
  endfunction

  // model update on the same edge the design registers
  always @(posedge clk) begin
    logic [15:0] wv;
    logic [7:0]  clr_s, set_e, clr_e;
    clr_s = '0; set_e = '0; clr_e = '0;
    if (acc_size == 2'd0)
      wv = acc_addr[0] ? {acc_wdata[7:0], 8'h00} : {8'h00, acc_wdata[7:0]};
    else
      wv = acc_wdata;
    if (acc_en && acc_wr && !want_bad(acc_addr, acc_size)) begin
      if (acc_addr[3:1] == 3'd0) clr_s = wv[7:0];
      if (acc_addr[3:1] == 3'd3) set_e = wv[7:0];
      if (acc_addr[3:1] == 3'd4) clr_e = wv[7:0];
    end
    if (!rst_n) begin
      m_stat <= '0;
      m_en   <= '0;
    end else begin
      m_stat <= (m_stat & ~clr_s) | evt;
      m_en   <= (m_en & ~clr_e) | set_e;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // R6: irq compared against the model on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) chk("R6 irq", {15'd0, irq}, {15'd0, |(m_stat & m_en)});
  end

  task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [15:0] d,
                    input logic [7:0] ev);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_size = sz; acc_wdata = d; evt = ev;
    #2 chk("R11 flag on write", {15'd0, bad_access}, {15'd0, want_bad(a, sz)});
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0; evt = '0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [1:0] sz, input string req);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a; acc_size = sz;
    #2;
    chk(req, acc_rdata, want_read(a, sz));
    chk("R11 flag on read", {15'd0, bad_access}, {15'd0, want_bad(a, sz)});
    acc_en = 1'b0;
  endtask

  task automatic rd_exp(input logic [3:0] a, input logic [1:0] sz, input logic [15:0] e,
                        input string req);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a; acc_size = sz;
    #2 chk(req, acc_rdata, e);
    acc_en = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] v);
    @(negedge clk);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {15'd0, irq}, 16'd0);
    rst_n = 1'b1;
    rd_exp(4'h0, 2'd1, 16'h0000, "R1 raw after reset");
    rd_exp(4'h4, 2'd1, 16'h0000, "R1 mask after reset");

    pulse(8'h0A);
    rd_exp(4'h0, 2'd1, 16'h000A, "R2 events latched");
    repeat (3) @(negedge clk);
    rd_exp(4'h0, 2'd1, 16'h000A, "R2 events sticky");

    wr(4'h6, 2'd1, 16'h0002, 8'h00);
    rd_exp(4'h4, 2'd1, 16'h0002, "R4 set port");
    rd_exp(4'h6, 2'd1, 16'h0000, "R4 set port reads zero");
    rd_exp(4'h2, 2'd1, 16'h0002, "R9 masked view");
    chk("R6 irq raised", {15'd0, irq}, 16'd1);

    wr(4'h0, 2'd1, 16'h0002, 8'h00);
    rd_exp(4'h0, 2'd1, 16'h0008, "R3 clear one flag only");
    chk("R6 irq dropped", {15'd0, irq}, 16'd0);

    wr(4'h0, 2'd1, 16'h0008, 8'h08);
    rd_exp(4'h0, 2'd1, 16'h0008, "R7 set beats clear");

    wr(4'h6, 2'd1, 16'h00FF, 8'h00);
    wr(4'h8, 2'd1, 16'h000F, 8'h00);
    rd_exp(4'h4, 2'd1, 16'h00F0, "R5 clear port");
    rd_exp(4'h8, 2'd1, 16'h0000, "R5 clear port reads zero");

    bus_busy = 1'b1;
    rd_exp(4'h0, 2'd1, 16'h1008, "R8 busy visible");
    wr(4'h0, 2'd1, 16'h1000, 8'h00);
    rd_exp(4'h0, 2'd1, 16'h1008, "R8 busy not writable");

    wr(4'h8, 2'd0, 16'h00FF, 8'h00);
    rd_exp(4'h4, 2'd1, 16'h0000, "R10 byte clear all");
    wr(4'h7, 2'd0, 16'h00FF, 8'h00);
    rd_exp(4'h4, 2'd1, 16'h0000, "R10 upper lane write");
    wr(4'h6, 2'd0, 16'hAB05, 8'h00);
    rd_exp(4'h4, 2'd1, 16'h0005, "R10 lower lane uses low data byte");
    rd_exp(4'h1, 2'd0, 16'h0010, "R10 upper lane read");
    rd_exp(4'h0, 2'd0, 16'h0008, "R10 lower lane read");

    wr(4'h6, 2'd2, 16'h00FF, 8'h00);
    rd_exp(4'h4, 2'd1, 16'h0005, "R11 word write ignored");
    rd_exp(4'h0, 2'd2, 16'h0000, "R11 word read zero");
    wr(4'h7, 2'd1, 16'h00FF, 8'h00);
    rd_exp(4'h4, 2'd1, 16'h0005, "R11 misaligned half ignored");
    rd_exp(4'h1, 2'd1, 16'h0000, "R11 misaligned read zero");

    wr(4'h2, 2'd1, 16'h00FF, 8'h00);
    wr(4'h4, 2'd1, 16'h00FF, 8'h00);
    rd_exp(4'h4, 2'd1, 16'h0005, "R12 view writes ignored (mask)");
    rd_exp(4'h0, 2'd1, 16'h1008, "R12 view writes ignored (status)");

    for (int k = 0; k < 1500; k++) begin
      int op;
      op = $urandom_range(0, 9);
      if ($urandom_range(0, 15) == 0) bus_busy = ~bus_busy;
      if (op < 3) pulse(8'($urandom) & 8'($urandom));
      else if (op < 6)
        wr(4'($urandom_range(0, 9)), 2'($urandom_range(0, 3)), 16'($urandom),
           8'($urandom) & 8'($urandom) & 8'($urandom));
      else rd(4'($urandom), 2'($urandom_range(0, 3)), "R9 random readback");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule